// File: doc/BRIEF.md
# Bit-Level Serial ROM Slave

This block is a 256-byte read-only serial memory slave on a two-wire bus. A host moves the clock line and the data line by rewriting a pair of register bits. Each write is presented to the block as a one-cycle update strobe that carries the new clock and data levels. The block compares every update with the levels it stored on the previous update. From that comparison it recognises start and stop conditions and rising clock edges, and it shifts bits in on those edges.

A transfer opens with a start condition. A command byte follows, then an address byte, and the slave acknowledges each of them. When the address byte is complete, the slave fetches the addressed byte from its constant memory. If the next transaction carries a read command, the slave sends that fetched byte out, most significant bit first, during the address phase of that transaction. The data line the host reads back is always the level the slave stored last. That level can be a forced-low acknowledge or an outgoing data bit.

Top module: `serial_rom_slave`

## Requirements
- R1: A synchronous active-high reset clears the bit counter, the pending-acknowledge flag, and the command, address and data bytes. It stores 1 for both line levels, so `sda_o` reads 1 after reset.
- R2: While no transfer is open (bit counter 0 and no acknowledge pending), every update is ignored apart from being stored, so `sda_o` equals the host's data level.
- R3: A start is an update where the data line changes to 0 and the clock is 1 in both the stored and the new sample. It sets the bit counter to 1 and clears the command byte. This holds even in the middle of a transfer.
- R4: A bit is taken only on a rising clock edge (stored clock 0, new clock 1) with the data level unchanged from the stored sample. A rising edge that comes with a data change counts no bit.
- R5: Command bits shift in MSB first while the counter is below 9. The bit that brings the counter to 9 schedules an acknowledge. On the next rising edge the slave stores 0 as its data level, clears the pending flag and takes no bit.
- R6: Counter values 9 to 16 shift host bits MSB first into the address byte. The bit that would reach 17 loads the data byte from memory at the assembled address, schedules an acknowledge and returns the counter to 0.
- R7: When bit 0 of the command byte is 1 (read), each address-phase rising edge stores the top bit of the data byte as the data level and shifts the data byte left. The byte fetched by the previous transaction therefore appears MSB first.
- R8: The memory byte at address a is the low 8 bits of (29*a + 165) XOR (a >> 2).
- R9: Without the update strobe, no state changes and `sda_o` holds its value whatever the line inputs do.
- R10: After the fetch acknowledge has been given, the slave is idle again, and further clocking without a new start produces no acknowledge and no data.
- R11: When bit 0 of the command byte is 0 (write), address-phase rising edges store the host's data level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | One-cycle strobe: new line levels present |
| scl_i | input | 1 | New clock-line level from the host |
| sda_i | input | 1 | New data-line level from the host |
| sda_o | output | 1 | Stored data-line level as read back by the host |

## Verification
A wrong bit counter moves the acknowledge. The forced-low level then appears at `sda_o` one rising edge early or late. The very next update after that edge shows the difference, because the host is driving 1 at that point. A corrupted address or memory word shows up only one transaction later, when a read streams the fetched byte out bit by bit. A stale idle or pending flag appears as an acknowledge or a data bit where the host level should be echoed.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int SRS_CMD_W  = 8;
    localparam int SRS_ADDR_W = 8;
    localparam int SRS_DATA_W = 8;
    localparam int SRS_SEED   = 165;

    // Kind of line event seen on one host update
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_START  = 3'd1,
        EV_STOP   = 3'd2,
        EV_IDLE   = 3'd3,
        EV_ACK    = 3'd4,
        EV_BIT    = 3'd5,
        EV_GLITCH = 3'd6,
        EV_OTHER  = 3'd7
    } srs_ev_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } srs_line_t;

    // Constant memory word generator; callers keep the low bits
    function automatic logic [31:0] srs_rom_word(input int idx, input int seed);
        int v;
        v = (idx * 29 + seed) ^ (idx >>> 2);
        return 32'(v);
    endfunction

endpackage

// File: rtl/srs_line_decode.sv
module srs_line_decode
    import srs_pkg::*;
(
    input  logic      upd_i,
    input  srs_line_t line_q,
    input  srs_line_t line_n,
    input  logic      busy_i,
    input  logic      ack_i,
    output srs_ev_e   ev_o
);

    logic both_high;
    logic sda_moved;
    logic scl_rise;

    assign both_high = line_q.scl & line_n.scl;
    assign sda_moved = line_q.sda ^ line_n.sda;
    assign scl_rise  = ~line_q.scl & line_n.scl;

    always_comb begin
        ev_o = EV_NONE;
        if (upd_i) begin
            if (both_high && sda_moved) begin
                ev_o = line_n.sda ? EV_STOP : EV_START;
            end else if (!busy_i) begin
                ev_o = EV_IDLE;
            end else if (scl_rise) begin
                if (ack_i) begin
                    ev_o = EV_ACK;
                end else if (!sda_moved) begin
                    ev_o = EV_BIT;
                end else begin
                    ev_o = EV_GLITCH;
                end
            end else begin
                ev_o = EV_OTHER;
            end
        end
    end

endmodule

// File: rtl/srs_rom.sv
module srs_rom
    import srs_pkg::*;
#(
    parameter int ADDR_W = SRS_ADDR_W,
    parameter int DATA_W = SRS_DATA_W,
    parameter int SEED   = SRS_SEED
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [31:0] full_w;
        assign full_w    = srs_rom_word(g, SEED);
        assign word_w[g] = full_w[DATA_W-1:0];
    end

    assign rd_data_o = word_w[rd_addr_i];

endmodule

// File: rtl/srs_seq.sv
module srs_seq
    import srs_pkg::*;
#(
    parameter int CMD_W  = SRS_CMD_W,
    parameter int ADDR_W = SRS_ADDR_W,
    parameter int DATA_W = SRS_DATA_W,
    parameter int TICK_W = $clog2(CMD_W + ADDR_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  srs_ev_e           ev_i,
    input  srs_line_t         line_n,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    output srs_line_t         line_q,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o,
    output logic [CMD_W-1:0]  cmd_o
);

    localparam logic [TICK_W-1:0] CMD_END  = TICK_W'(CMD_W + 1);
    localparam logic [TICK_W-1:0] ADDR_END = TICK_W'(CMD_W + ADDR_W + 1);

    typedef struct packed {
        srs_line_t         line;
        logic [TICK_W-1:0] tick;
        logic              ack;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } seq_state_t;

    seq_state_t st_q, st_n;
    logic [TICK_W-1:0] tick_inc;
    logic [ADDR_W-1:0] addr_shift;

    assign tick_inc   = st_q.tick + 1'b1;
    assign addr_shift = {st_q.addr[ADDR_W-2:0], line_n.sda};
    assign rom_addr_o = addr_shift;

    always_comb begin
        st_n = st_q;
        if (ev_i != EV_NONE) begin
            st_n.line = line_n;
        end
        case (ev_i)
            EV_START: begin
                st_n.tick = TICK_W'(1);
                st_n.cmd  = '0;
            end
            EV_ACK: begin
                st_n.line.sda = 1'b0;
                st_n.ack      = 1'b0;
            end
            EV_BIT: begin
                if (st_q.tick < CMD_END) begin
                    st_n.cmd  = {st_q.cmd[CMD_W-2:0], line_n.sda};
                    st_n.tick = tick_inc;
                    if (tick_inc == CMD_END) begin
                        st_n.ack = 1'b1;
                    end
                end else if (st_q.tick < ADDR_END) begin
                    if (st_q.cmd[0]) begin
                        st_n.line.sda = st_q.data[DATA_W-1];
                    end
                    st_n.addr = addr_shift;
                    st_n.data = {st_q.data[DATA_W-2:0], 1'b0};
                    st_n.tick = tick_inc;
                    if (tick_inc == ADDR_END) begin
                        st_n.data = rom_data_i;
                        st_n.ack  = 1'b1;
                        st_n.tick = '0;
                    end
                end else begin
                    st_n.line.sda = 1'b0;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.line.scl <= 1'b1;
            st_q.line.sda <= 1'b1;
            st_q.tick     <= '0;
            st_q.ack      <= 1'b0;
            st_q.cmd      <= '0;
            st_q.addr     <= '0;
            st_q.data     <= '0;
        end else begin
            st_q <= st_n;
        end
    end

    assign line_q = st_q.line;
    assign tick_o = st_q.tick;
    assign ack_o  = st_q.ack;
    assign cmd_o  = st_q.cmd;

endmodule

// File: rtl/serial_rom_slave.sv
module serial_rom_slave
    import srs_pkg::*;
#(
    parameter int CMD_W  = SRS_CMD_W,
    parameter int ADDR_W = SRS_ADDR_W,
    parameter int DATA_W = SRS_DATA_W,
    parameter int SEED   = SRS_SEED
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);

    localparam int TICK_W = $clog2(CMD_W + ADDR_W + 2);

    srs_line_t         line_n_w;
    srs_line_t         line_q_w;
    srs_ev_e           ev_w;
    logic [TICK_W-1:0] tick_w;
    logic              ack_w;
    logic [CMD_W-1:0]  cmd_w;
    logic [ADDR_W-1:0] rom_addr_w;
    logic [DATA_W-1:0] rom_data_w;
    logic              busy_w;

    assign line_n_w.scl = scl_i;
    assign line_n_w.sda = sda_i;
    assign busy_w       = (tick_w != '0) || ack_w;

    srs_line_decode u_decode (
        .upd_i  (upd_i),
        .line_q (line_q_w),
        .line_n (line_n_w),
        .busy_i (busy_w),
        .ack_i  (ack_w),
        .ev_o   (ev_w)
    );

    srs_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEED   (SEED)
    ) u_rom (
        .rd_addr_i (rom_addr_w),
        .rd_data_o (rom_data_w)
    );

    srs_seq #(
        .CMD_W  (CMD_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TICK_W (TICK_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev_w),
        .line_n     (line_n_w),
        .rom_data_i (rom_data_w),
        .rom_addr_o (rom_addr_w),
        .line_q     (line_q_w),
        .tick_o     (tick_w),
        .ack_o      (ack_w),
        .cmd_o      (cmd_w)
    );

    assign sda_o = line_q_w.sda;

endmodule

// File: rtl/srs_chk.sv
module srs_chk
    import srs_pkg::*;
#(
    parameter int CMD_W  = SRS_CMD_W,
    parameter int ADDR_W = SRS_ADDR_W,
    parameter int TICK_W = $clog2(CMD_W + ADDR_W + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_i,
    input logic              sda_i,
    input logic              sda_o,
    input srs_ev_e           ev,
    input logic [TICK_W-1:0] tick_q,
    input logic              ack_q,
    input logic [CMD_W-1:0]  cmd_q
);

    localparam logic [TICK_W-1:0] LAST_CMD  = TICK_W'(CMD_W);
    localparam logic [TICK_W-1:0] LAST_ADDR = TICK_W'(CMD_W + ADDR_W);

    // R1
    reset_level_chk: assert property (@(posedge clk) rst |=> sda_o);

    // R2
    idle_echo_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_IDLE |=> (tick_q == '0) && (sda_o == $past(sda_i)));

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_START |=> (tick_q == TICK_W'(1)) && (cmd_q == '0));

    // R4
    glitch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_GLITCH |=> $stable(tick_q));

    // R5
    cmd_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_BIT) && (tick_q == LAST_CMD) |=> ack_q);

    // R5
    ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_ACK |=> !sda_o && !ack_q);

    // R6
    fetch_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_BIT) && (tick_q == LAST_ADDR) |=> ack_q && (tick_q == '0));

    // R9
    no_update_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(sda_o) && $stable(tick_q));

endmodule

bind serial_rom_slave srs_chk #(
    .CMD_W  (CMD_W),
    .ADDR_W (ADDR_W),
    .TICK_W (TICK_W)
) u_srs_chk (
    .clk    (clk),
    .rst    (rst),
    .upd_i  (upd_i),
    .sda_i  (sda_i),
    .sda_o  (sda_o),
    .ev     (ev_w),
    .tick_q (tick_w),
    .ack_q  (ack_w),
    .cmd_q  (cmd_w)
);

// File: tb/serial_rom_slave_tb.sv
module serial_rom_slave_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    bit upd_seen = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    serial_rom_slave u_dut (
        .clk   (clk),
        .rst   (rst),
        .upd_i (upd),
        .scl_i (scl),
        .sda_i (sda),
        .sda_o (sda_o)
    );

    function automatic logic [7:0] rom_ref(input int a);
        int v;
        v = (a * 29 + 165) ^ (a >> 2);
        return v[7:0];
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: sda_o=%0b expected %0b", tag, got, exp);
        end
    endtask

    // Monitor: scoreboard pop after each update
    always @(posedge clk) upd_seen <= upd;

    initial begin
        forever begin
            @(negedge clk);
            if (upd_seen) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL scoreboard: result with no expected item");
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(sda_o, e, t);
                end
            end
        end
    end

    // Driver
    task automatic step(input bit c, input bit d, input bit e, input string tag);
        @(negedge clk);
        scl = c;
        sda = d;
        upd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic send_bit(input bit b, input bit exp_rise, input string tag);
        step(1'b0, b, b, tag);
        step(1'b1, b, exp_rise, tag);
        step(1'b0, b, b, tag);
    endtask

    task automatic bus_start(input string tag);
        step(1'b1, 1'b1, 1'b1, tag);
        step(1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic send_cmd(input logic [7:0] cmd, input int glitch_at, input string tag);
        for (int i = 7; i >= 0; i--) begin
            if (7 - i == glitch_at) begin
                step(1'b0, 1'b0, 1'b0, "R4 glitch");
                step(1'b1, 1'b1, 1'b1, "R4 glitch");
                step(1'b0, 1'b1, 1'b1, "R4 glitch");
            end
            send_bit(cmd[i], cmd[i], tag);
        end
    endtask

    task automatic wr_fetch(input logic [7:0] a);
        bus_start("R3 start");
        send_cmd(8'hA0, -1, "R11 cmd");
        send_bit(1'b1, 1'b0, "R5 cmd ack");
        for (int i = 7; i >= 0; i--) send_bit(a[i], a[i], "R11 addr echo");
        send_bit(1'b1, 1'b0, "R6 fetch ack");
    endtask

    task automatic rd_body(input logic [7:0] host, input logic [7:0] ex,
                           input int glitch_at, input bit hold);
        send_cmd(8'hA1, glitch_at, "R7 cmd");
        step(1'b0, 1'b1, 1'b1, "R5 cmd ack");
        step(1'b1, 1'b1, 1'b0, "R5 cmd ack");
        if (hold) begin
            @(negedge clk);
            scl = 1'b0;
            sda = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                scl = ~scl;
                sda = ~sda;
                check(sda_o, 1'b0, "R9 hold without update");
            end
        end
        step(1'b0, 1'b1, 1'b1, "R5 cmd ack");
        for (int i = 7; i >= 0; i--) send_bit(host[i], ex[i], "R7 R8 data out");
        send_bit(1'b1, 1'b0, "R6 fetch ack");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sda_o, 1'b1, "R1 reset level");

        // R2: clocking before any start is ignored
        for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b1, "R2 pre-start");
        send_bit(1'b0, 1'b0, "R2 pre-start");

        // Fetch address 0x3C, then read it with host address 0x5A
        wr_fetch(8'h3C);
        bus_start("R3 start");
        rd_body(8'h5A, rom_ref(8'h3C), -1, 1'b0);

        // R10: idle after fetch acknowledge
        send_bit(1'b1, 1'b1, "R10 idle");
        send_bit(1'b1, 1'b1, "R10 idle");
        send_bit(1'b0, 1'b0, "R10 idle");

        // Read of 0x5A with a glitch edge in the command and an update hold
        bus_start("R3 start");
        rd_body(8'h00, rom_ref(8'h5A), 4, 1'b1);

        // R3: restart in the middle of a command
        bus_start("R3 start");
        send_bit(1'b1, 1'b1, "R3 partial");
        send_bit(1'b0, 1'b0, "R3 partial");
        send_bit(1'b1, 1'b1, "R3 partial");
        step(1'b0, 1'b1, 1'b1, "R3 partial");
        step(1'b1, 1'b1, 1'b1, "R3 partial");
        step(1'b1, 1'b0, 1'b0, "R3 restart");
        rd_body(8'hFF, rom_ref(8'h00), -1, 1'b0);

        // Boundary address 0xFF
        bus_start("R3 start");
        rd_body(8'h80, rom_ref(8'hFF), -1, 1'b0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: %0d results missing", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule